// File: doc/BRIEF.md
# Reconfigurable LFSR Test Register

A small data-path register, three bits wide by default, that can be switched between ordinary use and two built-in self-test roles. In normal operation every bit captures its own data input on each clock edge. In generator mode the register runs as an autonomous linear feedback shift register and steps through a maximal-length pseudo-random sequence that can drive a circuit under test. In signature mode the same feedback shift keeps running, and each incoming data word is XORed into the shifted state, so a stream of responses is compressed into one signature.

Three control inputs select the role. A synchronous seed load, which has priority over every mode, places a known starting value in the register. The register contents are always visible on the parallel output. The stage numbering is fixed: bit 0 is the first stage, and the shift moves data from bit i to bit i+1. The width is a parameter. A built-in table of feedback taps covers the supported widths, and any width outside the table is refused when the design is elaborated.

Top module: `bist_lfsr_reg`

## Requirements
- R1: While `rst` is high, the next rising edge loads `RESET_SEED` (default 3'b001, which must be nonzero) into `q`. Reset outranks every other input.
- R2: When `rst` is low and `seed_ld` is high, the next edge loads `seed_val` into `q`, whatever the mode inputs are. A `seed_val` of zero loads 1 instead, so a seed load never leaves the register all-zero.
- R3: When `sel_func` is 1, the register is in normal mode whatever `sel_path` and `sel_sig` are. Each edge copies `din` into `q` bit for bit, with no feedback.
- R4: When `sel_func` is 0 and `sel_path` is 1, the register is also in normal mode, and each edge copies `din` into `q`.
- R5: When all three selects are 0, the register is in generator mode. For the 3-bit default, each edge gives `q[0]` = old `q[1]` XOR old `q[2]`, `q[1]` = old `q[0]` and `q[2]` = old `q[1]`. `din` has no effect in this mode.
- R6: In generator mode, starting from a nonzero seed, the register visits all 2^WIDTH-1 nonzero states (7 states at width 3) before it returns to the seed.
- R7: In generator mode, an all-zero `q` becomes 1 at the next edge.
- R8: When `sel_func` is 0, `sel_path` is 0 and `sel_sig` is 1, the register is in signature mode. Each edge loads the generator-mode next state of R5 XORed bit for bit with `din`.
- R9: A change on the select inputs governs the very next rising edge. `q` is the register itself, with no added pipeline stage.
- R10: The supported widths are 3 to 12 and 16. Elaborating with any other `WIDTH` stops with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `RESET_SEED` |
| seed_ld | input | 1 | Synchronous seed load; has priority over the selects |
| seed_val | input | WIDTH | Seed value; zero is replaced by 1 |
| din | input | WIDTH | Parallel data, one bit per stage |
| sel_func | input | 1 | 1 selects normal parallel load |
| sel_path | input | 1 | With `sel_func` at 0: 1 selects normal load, 0 selects a test role |
| sel_sig | input | 1 | In a test role: 0 selects the generator, 1 the signature analyzer |
| q | output | WIDTH | Current register contents |

## Verification
The bound checker checks, on every clock edge, how each edge should change the register. It covers reset, seed priority and zero-seed replacement, loading in both normal encodings, the generator feedback shift, recovery from an all-zero state, and signature folding. These per-edge rules do not reach the properties that only show up across a whole run. The bench's scenarios cover those: that the generator reaches every nonzero state and has a period of exactly seven, that a signature folded from a multi-word stream matches an independent model, and that the data input is ignored across a run in generator mode. The rejection of widths outside the tap table happens at elaboration, so only a build with such a width can show it.

// File: rtl/bist_lfsr_pkg.sv
package bist_lfsr_pkg;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'd0,
    MODE_GEN  = 2'd1,
    MODE_SIG  = 2'd2
  } lfsr_mode_e;

  // Feedback tap mask per width: bit k set means stage k+1 feeds stage 1.
  // Every entry is a primitive polynomial; zero marks an unsupported width (R10).
  function automatic logic [31:0] tap_mask(input int w);
    case (w)
      3:       return 32'h0000_0006;
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      8:       return 32'h0000_00B8;
      9:       return 32'h0000_0110;
      10:      return 32'h0000_0240;
      11:      return 32'h0000_0500;
      12:      return 32'h0000_0829;
      16:      return 32'h0000_D008;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/bist_lfsr_mode_dec.sv
module bist_lfsr_mode_dec
  import bist_lfsr_pkg::*;
(
  input  logic       sel_func,
  input  logic       sel_path,
  input  logic       sel_sig,
  output lfsr_mode_e mode
);

  // Normal load wins whenever either of the first two selects is high (R3, R4).
  always_comb begin
    if (sel_func || sel_path) begin
      mode = MODE_LOAD;
    end else if (sel_sig) begin
      mode = MODE_SIG;
    end else begin
      mode = MODE_GEN;
    end
  end

endmodule

// File: rtl/bist_lfsr_next.sv
module bist_lfsr_next
  import bist_lfsr_pkg::*;
#(
  parameter int              WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b110
) (
  input  lfsr_mode_e       mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             fb;
  logic [WIDTH-1:0] shifted;

  assign fb = ^(cur & TAPS);

  // Stage 0 takes the feedback; every later stage takes its predecessor.
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign shifted[i] = fb;
    end else begin : g_tail
      assign shifted[i] = cur[i-1];
    end
  end

  always_comb begin
    case (mode)
      MODE_LOAD: nxt = din;
      MODE_SIG:  nxt = shifted ^ din;
      MODE_GEN:  nxt = (cur == '0) ? ONE : shifted;
      default:   nxt = din;
    endcase
  end

endmodule

// File: rtl/bist_lfsr_reg.sv
module bist_lfsr_reg
  import bist_lfsr_pkg::*;
#(
  parameter int              WIDTH      = 3,
  parameter logic [WIDTH-1:0] RESET_SEED = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_ld,
  input  logic [WIDTH-1:0] seed_val,
  input  logic [WIDTH-1:0] din,
  input  logic             sel_func,
  input  logic             sel_path,
  input  logic             sel_sig,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] TAPS = WIDTH'(tap_mask(WIDTH));
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  // Elaboration-time guards (R10, R1).
  if (TAPS == '0) begin : g_bad_width
    $error("bist_lfsr_reg: no feedback taps defined for this WIDTH");
  end
  if (RESET_SEED == '0) begin : g_bad_seed
    $error("bist_lfsr_reg: RESET_SEED must be nonzero");
  end

  lfsr_mode_e       mode;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] seed_eff;
  logic [WIDTH-1:0] state_q;

  bist_lfsr_mode_dec u_dec (
    .sel_func (sel_func),
    .sel_path (sel_path),
    .sel_sig  (sel_sig),
    .mode     (mode)
  );

  bist_lfsr_next #(
    .WIDTH (WIDTH),
    .TAPS  (TAPS)
  ) u_next (
    .mode (mode),
    .cur  (state_q),
    .din  (din),
    .nxt  (nxt)
  );

  assign seed_eff = (seed_val == '0) ? ONE : seed_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RESET_SEED;
    end else if (seed_ld) begin
      state_q <= seed_eff;
    end else begin
      state_q <= nxt;
    end
  end

  assign q = state_q;

endmodule

// File: rtl/bist_lfsr_reg_chk.sv
module bist_lfsr_reg_chk
  import bist_lfsr_pkg::*;
#(
  parameter int              WIDTH      = 3,
  parameter logic [WIDTH-1:0] RESET_SEED = WIDTH'(1)
) (
  input logic             clk,
  input logic             rst,
  input logic             seed_ld,
  input logic [WIDTH-1:0] seed_val,
  input logic [WIDTH-1:0] din,
  input logic             sel_func,
  input logic             sel_path,
  input logic             sel_sig,
  input logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] TAPS = WIDTH'(tap_mask(WIDTH));

  logic gen_sel;
  logic sig_sel;
  assign gen_sel = !sel_func && !sel_path && !sel_sig;
  assign sig_sel = !sel_func && !sel_path && sel_sig;

  // R1
  reset_seed_chk: assert property (@(posedge clk) rst |=> q == RESET_SEED);

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_ld && seed_val != '0) |=> q == $past(seed_val));

  // R2
  seed_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_ld && seed_val == '0) |=> q == WIDTH'(1));

  // R3
  func_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && sel_func) |=> q == $past(din));

  // R4
  path_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && !sel_func && sel_path) |=> q == $past(din));

  // R5
  gen_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && gen_sel && q != '0) |=>
      (q[WIDTH-1:1] == $past(q[WIDTH-2:0])) && (q[0] == ^($past(q) & TAPS)));

  // R7
  gen_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && gen_sel && q == '0) |=> q == WIDTH'(1));

  // R8
  sig_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && sig_sel) |=>
      (q[WIDTH-1:1] == ($past(q[WIDTH-2:0]) ^ $past(din[WIDTH-1:1]))) &&
      (q[0] == ((^($past(q) & TAPS)) ^ $past(din[0]))));

endmodule

bind bist_lfsr_reg bist_lfsr_reg_chk #(
  .WIDTH      (WIDTH),
  .RESET_SEED (RESET_SEED)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .seed_ld  (seed_ld),
  .seed_val (seed_val),
  .din      (din),
  .sel_func (sel_func),
  .sel_path (sel_path),
  .sel_sig  (sel_sig),
  .q        (q)
);

// File: tb/bist_lfsr_reg_tb_top.sv
module bist_lfsr_reg_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       seed_ld;
  logic [2:0] seed_val;
  logic [2:0] din;
  logic       sel_func;
  logic       sel_path;
  logic       sel_sig;
  logic [2:0] q;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  bist_lfsr_reg #(.WIDTH(3), .RESET_SEED(3'b001)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .seed_ld  (seed_ld),
    .seed_val (seed_val),
    .din      (din),
    .sel_func (sel_func),
    .sel_path (sel_path),
    .sel_sig  (sel_sig),
    .q        (q)
  );

  // Generator next state from R5 (with R7 for the zero state).
  function automatic logic [2:0] gen_next(input logic [2:0] s);
    if (s == 3'b000) return 3'b001;
    return {s[1], s[0], s[1] ^ s[2]};
  endfunction

  // Signature next state from R8.
  function automatic logic [2:0] sig_next(input logic [2:0] s, input logic [2:0] d);
    return {s[1], s[0], s[1] ^ s[2]} ^ d;
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: q=%b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // One rising edge, then sample 1 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic f, input logic p, input logic s);
    sel_func = f;
    sel_path = p;
    sel_sig  = s;
  endtask

  task automatic load_seed(input logic [2:0] v);
    seed_ld  = 1'b1;
    seed_val = v;
    tick();
    seed_ld  = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    seed_ld = 1'b0;
    seed_val = 3'b000;
    din = 3'b110;
    set_mode(1'b1, 1'b0, 1'b0);
    tick();
    tick();
    chk("R1 reset seed", q, 3'b001);
    rst = 1'b0;
  endtask

  task automatic t_normal();
    // sel_func = 1 wins regardless of the other selects.
    set_mode(1'b1, 1'b0, 1'b1);
    din = 3'b101;
    tick();
    chk("R3 func load a", q, 3'b101);
    set_mode(1'b1, 1'b1, 1'b0);
    din = 3'b010;
    tick();
    chk("R3 func load b", q, 3'b010);
    din = 3'b000;
    tick();
    chk("R3 func load zero", q, 3'b000);
    set_mode(1'b0, 1'b1, 1'b1);
    din = 3'b111;
    tick();
    chk("R4 path load a", q, 3'b111);
    set_mode(1'b0, 1'b1, 1'b0);
    din = 3'b011;
    tick();
    chk("R4 path load b", q, 3'b011);
  endtask

  task automatic t_seed();
    // The seed load outranks normal mode.
    set_mode(1'b1, 1'b0, 1'b0);
    din = 3'b111;
    load_seed(3'b110);
    chk("R2 seed load", q, 3'b110);
    load_seed(3'b000);
    chk("R2 zero seed becomes one", q, 3'b001);
  endtask

  task automatic t_gen_step();
    logic [2:0] exp;
    set_mode(1'b0, 1'b0, 1'b0);
    load_seed(3'b100);
    exp = 3'b100;
    for (int i = 0; i < 5; i++) begin
      din = 3'(i * 3 + 1);  // must not matter
      exp = gen_next(exp);
      tick();
      chk("R5 generator step, din ignored", q, exp);
    end
  endtask

  task automatic t_period();
    logic [7:0] seen;
    int         steps;
    set_mode(1'b0, 1'b0, 1'b0);
    load_seed(3'b001);
    seen  = 8'h02;
    steps = 0;
    for (int i = 0; i < 20; i++) begin
      din = 3'(i);
      tick();
      steps++;
      if (q == 3'b001) break;
      seen[q] = 1'b1;
    end
    chk_int("R6 generator period", steps, 7);
    chk_int("R6 all nonzero states seen", int'(seen), 8'hFE);
  endtask

  task automatic t_zero_recover();
    set_mode(1'b1, 1'b0, 1'b0);
    din = 3'b000;
    tick();
    chk("R7 zero loaded", q, 3'b000);
    set_mode(1'b0, 1'b0, 1'b0);
    din = 3'b111;
    tick();
    chk("R7 generator escapes zero", q, 3'b001);
  endtask

  task automatic t_signature();
    logic [2:0] exp;
    set_mode(1'b0, 1'b0, 1'b1);
    load_seed(3'b101);
    exp = 3'b101;
    for (int i = 0; i < 9; i++) begin
      din = 3'((i * 5 + 3) & 7);
      exp = sig_next(exp, din);
      tick();
    end
    chk("R8 final signature", q, exp);
    // A zero state with nonzero data just takes the data.
    set_mode(1'b1, 1'b0, 1'b0);
    din = 3'b000;
    tick();
    set_mode(1'b0, 1'b0, 1'b1);
    din = 3'b110;
    tick();
    chk("R8 fold into zero state", q, 3'b110);
  endtask

  task automatic t_mode_switch();
    set_mode(1'b1, 1'b0, 1'b0);
    din = 3'b110;
    tick();
    chk("R9 normal before switch", q, 3'b110);
    set_mode(1'b0, 1'b0, 1'b0);
    din = 3'b001;
    tick();
    chk("R9 generator on next edge", q, gen_next(3'b110));
    set_mode(1'b0, 1'b0, 1'b1);
    din = 3'b011;
    tick();
    chk("R9 signature on next edge", q, sig_next(gen_next(3'b110), 3'b011));
    set_mode(1'b0, 1'b1, 1'b0);
    din = 3'b010;
    tick();
    chk("R9 back to load on next edge", q, 3'b010);
  endtask

  task automatic t_reset_priority();
    set_mode(1'b0, 1'b0, 1'b0);
    seed_ld = 1'b1;
    seed_val = 3'b111;
    rst = 1'b1;
    tick();
    chk("R1 reset outranks seed", q, 3'b001);
    rst = 1'b0;
    seed_ld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_seed();
    t_gen_step();
    t_period();
    t_zero_recover();
    t_signature();
    t_mode_switch();
    t_reset_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule